// File: doc/BRIEF.md
# Multi-Channel PID Filter with Ring-Buffer Write Pointers

This block receives transport packets that an upstream stage has already aligned. Each packet is 188 bytes long, and the first byte is marked by a start flag. The block captures a whole packet, takes its 13-bit packet identifier, and tests that identifier against a bank of channel entries. Each entry has its own identifier and match mask. An enabled channel whose masked identifier agrees with the packet receives a full copy of the packet. The copy goes into that channel's circular buffer in memory as a run of byte-address write requests.

Software programs every channel through a small register window. One register holds a channel index, and that index chooses which channel the per-channel registers reach. Each channel keeps:
- a buffer base address,
- a usable size and an interrupt threshold,
- a write position that hardware advances,
- a read position that software moves forward when it consumes data.

A channel flags a pending interrupt when enough data has built up. It flags an overlap when a packet had to be discarded because there was no room. The interrupt line is gated by a per-channel enable and by a global enable.

Top module: `pid_ring_filter`

## Requirements
- R1: After synchronous reset, every readable register reads 0, `irq` is 0, `in_ready` is 1 and `mem_wr_valid` is 0.
- R2: The register addresses are: 0 channel index, 1 channel-enable bits, 2 interrupt-enable bits, 3 global control (bit 0 is the global interrupt enable), 4 identifier/mask, 5 base, 6 size/threshold, 7 write position, 8 read position, 9 pending bits, 10 overlap bits. Addresses 4 to 8 reach only the channel selected by address 0. In address 4 the identifier sits in bits 12:0 and the mask in bits 28:16. In address 6 the threshold sits in bits 31:24 and the size in the low bits. Bit n of addresses 1, 2, 9 and 10 belongs to channel n.
- R3: The packet identifier is formed from the low 5 bits of byte 1 (as bits 12:8) followed by byte 2. A channel takes the packet when its enable bit is set and ((identifier XOR channel identifier) AND mask) is zero. A zero mask passes every identifier, and mask 0x1FFF demands an exact match.
- R4: Channels that take a packet are served one after another in ascending index order. Each receives 188 consecutive write requests at base plus write position, carrying the packet bytes in arrival order starting with byte 0.
- R5: The write position grows by one for each byte written and returns to 0 when it reaches the programmed size.
- R6: The buffered amount is (write − read) when write ≥ read, and otherwise (write + size − read). A packet is stored only if the buffered amount plus 188 is below the size. Otherwise nothing is written for that channel, its write position is kept, and its overlap bit is set. Software frees space by writing the read position.
- R7: After a packet has been stored in a channel, that channel's pending bit is set if the buffered amount is at least threshold × 188. Writing 1 to a pending bit clears it.
- R8: `irq` is high exactly when the global enable is set and some channel has both its pending bit and its interrupt-enable bit set.
- R9: When hardware sets a pending or overlap bit in the same cycle that software writes 1 to clear it, the bit ends up set.
- R10: `in_ready` is low while a captured packet is being distributed. Bytes presented without a preceding start flag are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Packet byte present |
| in_sop | input | 1 | Marks byte 0 of a packet |
| in_data | input | 8 | Packet byte |
| in_ready | output | 1 | Block accepts packet bytes |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_wr_valid | output | 1 | Byte write request |
| mem_wr_addr | output | 32 | Byte address of the request |
| mem_wr_data | output | 8 | Byte to write |
| irq | output | 1 | Interrupt request |

## Verification
Software can clear a status bit in the same cycle that the distribution engine sets it. The overlap bit is the case exercised here. The bench fills a small channel until the next packet cannot fit. It then sends that packet and issues a write-one-to-clear of the overlap bit on the register port in the cycle right after the last byte, which is when the engine examines that channel and rejects the packet. The overlap bit must read back as set afterwards. No write requests and no change of write position may appear for that packet.

// File: rtl/pidf_pkg.sv
`timescale 1ns/1ps
package pidf_pkg;

    localparam int PKT_LEN = 188;
    localparam int PID_W   = 13;

    typedef struct packed {
        logic [PID_W-1:0] mask;
        logic [PID_W-1:0] pid;
    } pid_sel_t;

    typedef enum logic [1:0] {
        ST_RX,
        ST_SCAN,
        ST_COPY,
        ST_EVAL
    } dist_state_e;

    typedef enum logic [3:0] {
        RA_SEL  = 4'd0,
        RA_ENA  = 4'd1,
        RA_IEN  = 4'd2,
        RA_GLB  = 4'd3,
        RA_PID  = 4'd4,
        RA_BASE = 4'd5,
        RA_SIZE = 4'd6,
        RA_WPOS = 4'd7,
        RA_RPOS = 4'd8,
        RA_PEND = 4'd9,
        RA_OVLP = 4'd10
    } reg_addr_e;

    function automatic logic pid_hit(input logic [PID_W-1:0] pkt_pid,
                                     input pid_sel_t        sel);
        return ((pkt_pid ^ sel.pid) & sel.mask) == '0;
    endfunction

    function automatic logic [31:0] ring_fill(input logic [31:0] wp,
                                              input logic [31:0] rp,
                                              input logic [31:0] size);
        return (wp >= rp) ? (wp - rp) : (wp + size - rp);
    endfunction

endpackage

// File: rtl/pidf_pkt_capture.sv
`timescale 1ns/1ps
module pidf_pkt_capture
    import pidf_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic             in_valid,
    input  logic             in_sop,
    input  logic [7:0]       in_data,
    input  logic [CNT_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             done,
    output logic [PID_W-1:0] pid
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_LEN - 1);

    logic [7:0]       pkt_q [PKT_LEN];
    logic [CNT_W-1:0] cnt_q;
    logic             take;
    logic             store;

    assign take  = accept && in_valid;
    assign store = take && (in_sop || (cnt_q != '0));
    assign done  = take && !in_sop && (cnt_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (take) begin
            if (in_sop)
                cnt_q <= CNT_W'(1);
            else if (cnt_q != '0)
                cnt_q <= (cnt_q == LAST_IDX) ? '0 : cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (store)
            pkt_q[in_sop ? '0 : cnt_q] <= in_data;
    end

    assign rd_data = pkt_q[rd_idx];
    assign pid     = {pkt_q[1][4:0], pkt_q[2]};

endmodule

// File: rtl/pidf_chan_bank.sv
`timescale 1ns/1ps
module pidf_chan_bank
    import pidf_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int POS_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_pid,
    input  logic              wr_base,
    input  logic              wr_size,
    input  logic              wr_wpos,
    input  logic              wr_rpos,
    input  logic              hw_step,
    input  pid_sel_t          pid_in,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [POS_W-1:0]  pos_in,
    input  logic [7:0]        thresh_in,
    output pid_sel_t          sel,
    output logic [ADDR_W-1:0] base,
    output logic [POS_W-1:0]  size,
    output logic [7:0]        thresh,
    output logic [POS_W-1:0]  wpos,
    output logic [POS_W-1:0]  rpos
);
    logic [POS_W-1:0] wpos_inc;

    assign wpos_inc = wpos + POS_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel    <= '0;
            base   <= '0;
            size   <= '0;
            thresh <= '0;
            wpos   <= '0;
            rpos   <= '0;
        end else begin
            if (wr_pid)  sel  <= pid_in;
            if (wr_base) base <= base_in;
            if (wr_size) begin
                size   <= pos_in;
                thresh <= thresh_in;
            end
            if (wr_rpos) rpos <= pos_in;
            // hardware advance takes precedence over a software write
            if (hw_step)
                wpos <= (wpos_inc == size) ? '0 : wpos_inc;
            else if (wr_wpos)
                wpos <= pos_in;
        end
    end

endmodule

// File: rtl/pidf_lowest_pick.sv
`timescale 1ns/1ps
module pidf_lowest_pick #(
    parameter int N     = 4,
    parameter int IDX_W = 2
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/pid_ring_filter.sv
`timescale 1ns/1ps
module pid_ring_filter
    import pidf_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 32,
    parameter int POS_W  = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic        in_sop,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    input  logic        reg_we,
    input  logic [3:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_wr_valid,
    output logic [31:0] mem_wr_addr,
    output logic [7:0]  mem_wr_data,
    output logic        irq
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int CNT_W = $clog2(PKT_LEN);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PKT_LEN - 1);

    dist_state_e       state_q;
    logic [IDX_W-1:0]  ch_idx_q, cur_q, pick_idx;
    logic [NUM_CH-1:0] ena_q, ien_q, pend_q, ovlp_q, todo_q;
    logic [NUM_CH-1:0] hit_vec, hw_step, pend_set, ovlp_set;
    logic              glb_en_q, pick_any, room_ok, cap_done;
    logic [CNT_W-1:0]  byte_idx_q;
    logic [PID_W-1:0]  cap_pid;
    logic [ADDR_W-1:0] cur_base;

    pid_sel_t          ch_sel    [NUM_CH];
    logic [ADDR_W-1:0] ch_base   [NUM_CH];
    logic [POS_W-1:0]  ch_size   [NUM_CH];
    logic [7:0]        ch_thresh [NUM_CH];
    logic [POS_W-1:0]  ch_wpos   [NUM_CH];
    logic [POS_W-1:0]  ch_rpos   [NUM_CH];
    logic [31:0]       ch_fill   [NUM_CH];

    // ---------------- register write decode ----------------
    logic wa_sel, wa_pid, wa_base, wa_size, wa_wpos, wa_rpos, wa_pend, wa_ovlp;
    assign wa_sel  = reg_we && (reg_addr == RA_SEL);
    assign wa_pid  = reg_we && (reg_addr == RA_PID);
    assign wa_base = reg_we && (reg_addr == RA_BASE);
    assign wa_size = reg_we && (reg_addr == RA_SIZE);
    assign wa_wpos = reg_we && (reg_addr == RA_WPOS);
    assign wa_rpos = reg_we && (reg_addr == RA_RPOS);
    assign wa_pend = reg_we && (reg_addr == RA_PEND);
    assign wa_ovlp = reg_we && (reg_addr == RA_OVLP);

    pid_sel_t pid_in;
    assign pid_in.pid  = reg_wdata[PID_W-1:0];
    assign pid_in.mask = reg_wdata[16 +: PID_W];

    // ---------------- packet capture ----------------
    assign in_ready = (state_q == ST_RX);

    pidf_pkt_capture #(.CNT_W(CNT_W)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .accept   (in_ready),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_data  (in_data),
        .rd_idx   (byte_idx_q),
        .rd_data  (mem_wr_data),
        .done     (cap_done),
        .pid      (cap_pid)
    );

    // ---------------- channel banks ----------------
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic here;
        assign here       = (ch_idx_q == IDX_W'(c));
        assign hw_step[c] = (state_q == ST_COPY) && (cur_q == IDX_W'(c));
        assign hit_vec[c] = ena_q[c] && pid_hit(cap_pid, ch_sel[c]);
        assign ch_fill[c] = ring_fill(32'(ch_wpos[c]), 32'(ch_rpos[c]), 32'(ch_size[c]));

        pidf_chan_bank #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_bank (
            .clk       (clk),
            .rst       (rst),
            .wr_pid    (wa_pid  && here),
            .wr_base   (wa_base && here),
            .wr_size   (wa_size && here),
            .wr_wpos   (wa_wpos && here),
            .wr_rpos   (wa_rpos && here),
            .hw_step   (hw_step[c]),
            .pid_in    (pid_in),
            .base_in   (reg_wdata[ADDR_W-1:0]),
            .pos_in    (reg_wdata[POS_W-1:0]),
            .thresh_in (reg_wdata[31:24]),
            .sel       (ch_sel[c]),
            .base      (ch_base[c]),
            .size      (ch_size[c]),
            .thresh    (ch_thresh[c]),
            .wpos      (ch_wpos[c]),
            .rpos      (ch_rpos[c])
        );
    end

    pidf_lowest_pick #(.N(NUM_CH), .IDX_W(IDX_W)) u_pick (
        .req (todo_q),
        .any (pick_any),
        .idx (pick_idx)
    );

    assign room_ok = (ch_fill[pick_idx] + 32'(PKT_LEN)) < 32'(ch_size[pick_idx]);

    always_comb begin
        ovlp_set = '0;
        pend_set = '0;
        if (state_q == ST_SCAN && pick_any && !room_ok)
            ovlp_set[pick_idx] = 1'b1;
        if (state_q == ST_EVAL &&
            ch_fill[cur_q] >= 32'(ch_thresh[cur_q]) * 32'(PKT_LEN))
            pend_set[cur_q] = 1'b1;
    end

    // ---------------- distribution engine ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_RX;
            todo_q     <= '0;
            cur_q      <= '0;
            byte_idx_q <= '0;
        end else begin
            case (state_q)
                ST_RX: if (cap_done) begin
                    todo_q  <= hit_vec;
                    state_q <= ST_SCAN;
                end
                ST_SCAN: begin
                    if (!pick_any) begin
                        state_q <= ST_RX;
                    end else begin
                        cur_q            <= pick_idx;
                        todo_q[pick_idx] <= 1'b0;
                        if (room_ok) begin
                            byte_idx_q <= '0;
                            state_q    <= ST_COPY;
                        end
                    end
                end
                ST_COPY: begin
                    byte_idx_q <= byte_idx_q + CNT_W'(1);
                    if (byte_idx_q == LAST_IDX) state_q <= ST_EVAL;
                end
                default: state_q <= ST_SCAN;
            endcase
        end
    end

    // ---------------- global registers and status ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            ch_idx_q <= '0;
            ena_q    <= '0;
            ien_q    <= '0;
            glb_en_q <= 1'b0;
            pend_q   <= '0;
            ovlp_q   <= '0;
        end else begin
            if (wa_sel) ch_idx_q <= reg_wdata[IDX_W-1:0];
            if (reg_we && reg_addr == RA_ENA) ena_q <= reg_wdata[NUM_CH-1:0];
            if (reg_we && reg_addr == RA_IEN) ien_q <= reg_wdata[NUM_CH-1:0];
            if (reg_we && reg_addr == RA_GLB) glb_en_q <= reg_wdata[0];
            pend_q <= (pend_q & ~(wa_pend ? reg_wdata[NUM_CH-1:0] : '0)) | pend_set;
            ovlp_q <= (ovlp_q & ~(wa_ovlp ? reg_wdata[NUM_CH-1:0] : '0)) | ovlp_set;
        end
    end

    assign irq = glb_en_q && |(pend_q & ien_q);

    // ---------------- memory request ----------------
    assign cur_base     = ch_base[cur_q];
    assign mem_wr_valid = (state_q == ST_COPY);
    assign mem_wr_addr  = 32'(cur_base + ADDR_W'(ch_wpos[cur_q]));

    // ---------------- read window ----------------
    always_comb begin
        case (reg_addr)
            RA_SEL:  reg_rdata = 32'(ch_idx_q);
            RA_ENA:  reg_rdata = 32'(ena_q);
            RA_IEN:  reg_rdata = 32'(ien_q);
            RA_GLB:  reg_rdata = 32'(glb_en_q);
            RA_PID:  reg_rdata = {3'b0, ch_sel[ch_idx_q].mask, 3'b0, ch_sel[ch_idx_q].pid};
            RA_BASE: reg_rdata = 32'(ch_base[ch_idx_q]);
            RA_SIZE: reg_rdata = {ch_thresh[ch_idx_q], 24'(ch_size[ch_idx_q])};
            RA_WPOS: reg_rdata = 32'(ch_wpos[ch_idx_q]);
            RA_RPOS: reg_rdata = 32'(ch_rpos[ch_idx_q]);
            RA_PEND: reg_rdata = 32'(pend_q);
            RA_OVLP: reg_rdata = 32'(ovlp_q);
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pidf_checker.sv
`timescale 1ns/1ps
module pidf_checker #(
    parameter int ADDR_W = 32,
    parameter int POS_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_ready,
    input logic              mem_wr_valid,
    input logic [31:0]       mem_wr_addr,
    input logic              irq,
    input logic              glb_en,
    input logic [ADDR_W-1:0] cur_base,
    input logic [POS_W-1:0]  cur_size
);
    // R10
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> !in_ready);

    // R5
    ring_bound_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_valid |-> (ADDR_W'(mem_wr_addr) - cur_base) < ADDR_W'(cur_size));

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !glb_en |-> !irq);

    // R1
    reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && in_ready && !mem_wr_valid));
endmodule

bind pid_ring_filter pidf_checker #(.ADDR_W(ADDR_W), .POS_W(POS_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_ready     (in_ready),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_addr  (mem_wr_addr),
    .irq          (irq),
    .glb_en       (glb_en_q),
    .cur_base     (cur_base),
    .cur_size     (ch_size[cur_q])
);

// File: tb/pid_ring_filter_tb_top.sv
`timescale 1ns/1ps
module pid_ring_filter_tb_top;

    localparam logic [3:0] A_SEL = 4'd0, A_ENA = 4'd1, A_IEN = 4'd2, A_GLB = 4'd3,
                           A_PID = 4'd4, A_BASE = 4'd5, A_SIZE = 4'd6, A_WPOS = 4'd7,
                           A_RPOS = 4'd8, A_PEND = 4'd9, A_OVLP = 4'd10;

    // {identifier[12:0], expected taking channels[3:0]}
    localparam logic [16:0] VEC [6] = '{
        {13'h0100, 4'b0111},
        {13'h01A5, 4'b0110},
        {13'h0055, 4'b0100},
        {13'h1FFF, 4'b0100},
        {13'h0000, 4'b0100},
        {13'h0101, 4'b0110}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_sop, in_ready;
    logic [7:0]  in_data;
    logic        reg_we;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        mem_wr_valid;
    logic [31:0] mem_wr_addr;
    logic [7:0]  mem_wr_data;
    logic        irq;

    always #10 clk = ~clk;

    pid_ring_filter dut_i (
        .clk (clk), .rst (rst),
        .in_valid (in_valid), .in_sop (in_sop), .in_data (in_data), .in_ready (in_ready),
        .reg_we (reg_we), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .mem_wr_valid (mem_wr_valid), .mem_wr_addr (mem_wr_addr), .mem_wr_data (mem_wr_data),
        .irq (irq)
    );

    int          n_chk = 0;
    int          n_err = 0;
    int          wr_cnt = 0;
    logic        first_pend = 1'b0;
    logic [31:0] first_addr;
    logic [7:0]  first_data;
    logic        busy_seen;
    logic        finished = 1'b0;
    logic [31:0] rd;
    logic [31:0] wp_b [4];
    logic [31:0] wp_a [4];

    always @(negedge clk) begin
        if (mem_wr_valid) begin
            wr_cnt++;
            if (first_pend) begin
                first_addr = mem_wr_addr;
                first_data = mem_wr_data;
                first_pend = 1'b0;
            end
        end
    end

    function automatic logic [31:0] base_of(input int c);
        return 32'h1000_0000 + (32'(c) << 16);
    endfunction

    task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chan_rd(input int c, input logic [3:0] a, output logic [31:0] d);
        reg_wr(A_SEL, 32'(c));
        reg_rd(a, d);
    endtask

    task automatic send_pkt(input logic [12:0] pid, input bit collide);
        while (!in_ready) @(negedge clk);
        for (int i = 0; i < 188; i++) begin
            in_valid = 1'b1;
            in_sop   = (i == 0);
            in_data  = (i == 0) ? 8'h47 : (i == 1) ? {3'b0, pid[12:8]} :
                       (i == 2) ? pid[7:0] : 8'(i);
            @(negedge clk);
        end
        in_valid  = 1'b0;
        in_sop    = 1'b0;
        busy_seen = !in_ready;
        if (collide) reg_wr(A_OVLP, 32'h8);
        do @(negedge clk); while (!in_ready);
    endtask

    initial begin
        #3000000;
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic all_zero;
        int   low;
        rst = 1'b1; in_valid = 1'b0; in_sop = 1'b0; in_data = '0;
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        all_zero = 1'b1;
        for (int a = 0; a <= 10; a++) begin
            reg_rd(4'(a), rd);
            if (rd != 0) all_zero = 1'b0;
        end
        expect_eq("R1 registers zero", 32'(all_zero), 32'd1);
        expect_eq("R1 irq", 32'(irq), 32'd0);
        expect_eq("R1 in_ready", 32'(in_ready), 32'd1);
        expect_eq("R1 mem_wr_valid", 32'(mem_wr_valid), 32'd0);

        // configuration: ch0 exact 0x100, ch1 masked 0x1Fxx, ch2 passes all, ch3 exact 0x055
        for (int c = 0; c < 4; c++) begin
            reg_wr(A_SEL, 32'(c));
            reg_wr(A_BASE, base_of(c));
            if (c == 3) begin
                reg_wr(A_PID, {3'b0, 13'h1FFF, 3'b0, 13'h0055});
                reg_wr(A_SIZE, {8'd2, 8'h0, 16'd400});
            end else begin
                reg_wr(A_PID, (c == 0) ? {3'b0, 13'h1FFF, 3'b0, 13'h0100} :
                              (c == 1) ? {3'b0, 13'h1F00, 3'b0, 13'h0100} : 32'h0);
                reg_wr(A_SIZE, {8'd255, 8'h0, 16'd4000});
            end
        end
        reg_wr(A_ENA, 32'h7);

        // R2 indexed window
        chan_rd(1, A_BASE, rd);
        expect_eq("R2 ch1 base", rd, 32'h1001_0000);
        reg_rd(A_PID, rd);
        expect_eq("R2 ch1 pid/mask fields", rd, 32'h1F00_0100);
        chan_rd(3, A_SIZE, rd);
        expect_eq("R2 ch3 size/threshold", rd, 32'h0200_0190);

        // R10 bytes without a start flag are ignored
        wr_cnt = 0;
        for (int i = 0; i < 200; i++) begin
            in_valid = 1'b1; in_sop = 1'b0; in_data = 8'(i);
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        expect_eq("R10 stray bytes write nothing", 32'(wr_cnt), 32'd0);
        chan_rd(2, A_WPOS, rd);
        expect_eq("R10 stray bytes keep wpos", rd, 32'd0);

        // R3/R4 table of identifiers
        for (int v = 0; v < 6; v++) begin
            for (int c = 0; c < 4; c++) chan_rd(c, A_WPOS, wp_b[c]);
            low = 0;
            for (int c = 3; c >= 0; c--) if (VEC[v][c]) low = c;
            wr_cnt = 0;
            first_pend = 1'b1;
            send_pkt(VEC[v][16:4], 1'b0);
            for (int c = 0; c < 4; c++) begin
                chan_rd(c, A_WPOS, wp_a[c]);
                expect_eq($sformatf("R3 vec%0d ch%0d wpos", v, c), wp_a[c],
                          wp_b[c] + (VEC[v][c] ? 32'd188 : 32'd0));
            end
            expect_eq($sformatf("R4 vec%0d write count", v), 32'(wr_cnt),
                      32'(188 * $countones(VEC[v][3:0])));
            expect_eq($sformatf("R4 vec%0d first address", v), first_addr,
                      base_of(low) + wp_b[low]);
            expect_eq($sformatf("R4 vec%0d first byte", v), 32'(first_data), 32'h47);
        end

        // directed: ch3 alone, size 400, threshold 2
        reg_wr(A_ENA, 32'h8);
        reg_wr(A_SEL, 32'd3);
        reg_wr(A_WPOS, 32'd300);
        reg_wr(A_RPOS, 32'd300);
        reg_wr(A_IEN, 32'h8);

        wr_cnt = 0;
        first_pend = 1'b1;
        send_pkt(13'h0055, 1'b0);
        expect_eq("R10 in_ready low while distributing", 32'(busy_seen), 32'd1);
        expect_eq("R4 first address at wpos 300", first_addr, base_of(3) + 32'd300);
        expect_eq("R5 wrap count", 32'(wr_cnt), 32'd188);
        chan_rd(3, A_WPOS, rd);
        expect_eq("R5 wpos wraps to 88", rd, 32'd88);
        reg_rd(A_PEND, rd);
        expect_eq("R7 below threshold", rd, 32'd0);

        send_pkt(13'h0055, 1'b0);
        chan_rd(3, A_WPOS, rd);
        expect_eq("R6 fill 188 accepted", rd, 32'd276);
        reg_rd(A_PEND, rd);
        expect_eq("R7 pending at threshold", rd, 32'h8);
        expect_eq("R8 irq gated by global", 32'(irq), 32'd0);
        reg_wr(A_GLB, 32'd1);
        expect_eq("R8 irq with global", 32'(irq), 32'd1);

        wr_cnt = 0;
        send_pkt(13'h0055, 1'b1);
        expect_eq("R6 dropped packet writes nothing", 32'(wr_cnt), 32'd0);
        chan_rd(3, A_WPOS, rd);
        expect_eq("R6 dropped packet keeps wpos", rd, 32'd276);
        reg_rd(A_OVLP, rd);
        expect_eq("R9 set beats same-cycle clear", rd, 32'h8);

        reg_wr(A_OVLP, 32'h8);
        reg_rd(A_OVLP, rd);
        expect_eq("R6 overlap write-one clears", rd, 32'd0);
        reg_wr(A_PEND, 32'h8);
        reg_rd(A_PEND, rd);
        expect_eq("R7 pending write-one clears", rd, 32'd0);
        expect_eq("R8 irq falls with pending", 32'(irq), 32'd0);

        reg_wr(A_SEL, 32'd3);
        reg_wr(A_RPOS, 32'd276);
        wr_cnt = 0;
        send_pkt(13'h0055, 1'b0);
        expect_eq("R6 consumed space accepts packet", 32'(wr_cnt), 32'd188);
        chan_rd(3, A_WPOS, rd);
        expect_eq("R5 wpos wraps to 64", rd, 32'd64);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule